// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog for a processor subsystem. Software writes a 16-bit control word that arms the watchdog, chooses its timeout, and sets its freeze and reset-routing options. After that, software must keep proving it is alive. It does so by writing a two-word key to a separate service register. If the countdown runs out before a correct key pair arrives, the block raises a system reset pulse. It can also raise an external reset pulse.

Time is counted in half-second ticks. A prescaler divides the input clock by `PRE_DIV` to make these ticks. The timeout field stores the number of ticks minus one. Only the ordered pair 0x5555 followed by 0xAAAA restarts the countdown, so a single stray write cannot keep a hung program alive. The enable bit can only be set, never cleared, until the next hardware reset. The countdown can pause while a low-power or debug condition is present, if software has allowed that pause.

Top module: `keysvc_wdog`

## Requirements
- R1: After reset, `sys_rst_o` and `ext_rst_o` are low, the watchdog is disabled and the timeout field is zero.
- R2: A write to the service register (`wr_sel`=1) of 0x5555, followed by a service write of 0xAAAA, reloads the countdown. The next timeout pulse then starts (N+1)×`PRE_DIV` cycles after the 0xAAAA write, where N is control bits [15:8].
- R3: Writing 1 to control bit 2 enables the watchdog and loads the countdown, counted from that write. A later control write with bit 2 at 0 does not disable it.
- R4: If the timeout field is left at its reset value of zero, enabling gives a timeout of exactly `PRE_DIV` cycles.
- R5: After 0x5555, any service write other than 0xAAAA or 0x5555 disarms the key checker. A repeated 0x5555 keeps it armed. 0xAAAA without a preceding arm does not reload. A second 0xAAAA after a valid pair does not reload. Control writes do not change the armed state.
- R6: While control bit 0 is 1 and `lowpwr_i` is high, the countdown and the prescaler hold. When bit 0 is 0, `lowpwr_i` has no effect.
- R7: While control bit 1 is 1 and `debug_i` is high, the countdown and the prescaler hold.
- R8: On expiry, `sys_rst_o` goes high for exactly `PULSE_CYC` cycles. The countdown then reloads and runs again, so the next expiry follows a full timeout later.
- R9: `ext_rst_o` pulses together with `sys_rst_o` on expiry only when control bit 3 was 1 at expiry. It is never high without `sys_rst_o`.
- R10: A control write with bit 4 at 0 produces one `sys_rst_o` pulse of `PULSE_CYC` cycles with `ext_rst_o` low, whether or not the watchdog is enabled.
- R11: While the watchdog is disabled, service writes cause no reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the service register |
| wr_data | input | 16 | Write data |
| lowpwr_i | input | 1 | Low-power mode indication |
| debug_i | input | 1 | Debug halt indication |
| sys_rst_o | output | 1 | System reset pulse |
| ext_rst_o | output | 1 | External reset pulse |

## Verification
The hardest cases are the key sequences that must not reload the countdown. Examples are a broken pair, an unarmed 0xAAAA, and a second 0xAAAA after a valid pair. None of them shows up at any output. The stimulus makes them visible through timing. Every run starts from reset with the enable write. Each key write lands exactly two cycles after the one before it. The bench then measures how many cycles pass from the last key write to the rising edge of `sys_rst_o`. A reload that should not have happened moves that edge by a known number of cycles. The freeze cases are handled the same way: the freeze is held for a fixed window, and the bench expects the expiry to be late by exactly that window.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    // Control word bit positions
    localparam int unsigned BIT_LP     = 0;
    localparam int unsigned BIT_DBG    = 1;
    localparam int unsigned BIT_EN     = 2;
    localparam int unsigned BIT_EXT    = 3;
    localparam int unsigned BIT_SRST_N = 4;
    localparam int unsigned TMO_LO     = 8;
    localparam int unsigned TMO_W      = 8;

    localparam logic [15:0] KEY_ARM  = 16'h5555;
    localparam logic [15:0] KEY_FIRE = 16'hAAAA;

    typedef struct packed {
        logic [TMO_W-1:0] tmo;
        logic             ext_sel;
        logic             en;
        logic             dbg_stop;
        logic             lp_stop;
    } wdk_ctrl_t;

endpackage

// File: rtl/wdk_keychk.sv
module wdk_keychk
    import wdk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_wr,
    input  logic [15:0] svc_data,
    output logic        svc_ok,
    output logic        armed_o
);

    typedef struct packed {
        logic armed;
    } key_st_t;

    key_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        svc_ok = 1'b0;
        if (svc_wr) begin
            if (svc_data == KEY_ARM) begin
                st_d.armed = 1'b1;
            end else begin
                svc_ok     = st_q.armed && (svc_data == KEY_FIRE);
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;

endmodule

// File: rtl/wdk_prescale.sv
module wdk_prescale #(
    parameter int unsigned PRE_DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);

    localparam int unsigned CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == LAST);
        if (clear) begin
            st_d.cnt = '0;
        end else if (run) begin
            st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/wdk_countdown.sv
module wdk_countdown #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] tmo_val,
    input  logic             tick,
    output logic             expire,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cd_st_t;

    cd_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                expire   = 1'b1;
                st_d.cnt = tmo_val;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/keysvc_wdog.sv
module keysvc_wdog
    import wdk_pkg::*;
#(
    parameter int unsigned PRE_DIV   = 50_000_000,
    parameter int unsigned PULSE_CYC = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [15:0] wr_data,
    input  logic        lowpwr_i,
    input  logic        debug_i,
    output logic        sys_rst_o,
    output logic        ext_rst_o
);

    localparam int unsigned PW = $clog2(PULSE_CYC + 1);
    localparam logic [PW-1:0] PULSE_LEN = PW'(PULSE_CYC);

    typedef struct packed {
        wdk_ctrl_t     ctrl;
        logic [PW-1:0] pcnt;
        logic          ext_flag;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             ctrl_wr, svc_wr, svc_ok, armed;
    logic             en_rise, reload, frozen, run, tick, expire, soft_req;
    logic [TMO_W-1:0] load_val, cnt_now;

    assign ctrl_wr  = wr_en && !wr_sel;
    assign svc_wr   = wr_en &&  wr_sel;
    assign en_rise  = ctrl_wr && wr_data[BIT_EN] && !st_q.ctrl.en;
    assign reload   = en_rise || (svc_ok && st_q.ctrl.en);
    assign load_val = en_rise ? wr_data[TMO_LO +: TMO_W] : st_q.ctrl.tmo;
    assign frozen   = (lowpwr_i && st_q.ctrl.lp_stop) || (debug_i && st_q.ctrl.dbg_stop);
    assign run      = st_q.ctrl.en && !frozen;
    assign soft_req = ctrl_wr && !wr_data[BIT_SRST_N];

    wdk_keychk u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr   (svc_wr),
        .svc_data (wr_data),
        .svc_ok   (svc_ok),
        .armed_o  (armed)
    );

    wdk_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (reload),
        .run   (run),
        .tick  (tick)
    );

    wdk_countdown #(.CNT_W(TMO_W)) u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (load_val),
        .tmo_val  (st_q.ctrl.tmo),
        .tick     (tick),
        .expire   (expire),
        .cnt_o    (cnt_now)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ctrl.tmo      = wr_data[TMO_LO +: TMO_W];
            st_d.ctrl.ext_sel  = wr_data[BIT_EXT];
            st_d.ctrl.en       = st_q.ctrl.en | wr_data[BIT_EN];
            st_d.ctrl.dbg_stop = wr_data[BIT_DBG];
            st_d.ctrl.lp_stop  = wr_data[BIT_LP];
        end
        if (st_q.pcnt != '0) begin
            st_d.pcnt = st_q.pcnt - 1'b1;
        end else if (expire) begin
            st_d.pcnt     = PULSE_LEN;
            st_d.ext_flag = st_q.ctrl.ext_sel;
        end else if (soft_req) begin
            st_d.pcnt     = PULSE_LEN;
            st_d.ext_flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sys_rst_o = (st_q.pcnt != '0);
    assign ext_rst_o = (st_q.pcnt != '0) && st_q.ext_flag;

endmodule

// File: rtl/keysvc_wdog_chk.sv
module keysvc_wdog_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_rst_o,
    input logic             ext_rst_o,
    input logic             en_q,
    input logic             lp_stop,
    input logic             lowpwr_i,
    input logic             svc_ok,
    input logic             wr_en,
    input logic [CNT_W-1:0] tmo_q,
    input logic [CNT_W-1:0] cnt_q
);

    // R3: enable never falls back while out of reset
    a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q) |-> en_q);

    // R2: accepted key pair loads the programmed timeout
    a_r2_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ok && en_q) |=> (cnt_q == $past(tmo_q)));

    // R6: low-power freeze holds the count
    a_r6_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && lp_stop && lowpwr_i && !wr_en) |=> $stable(cnt_q));

    // R8: a started pulse lasts more than one cycle
    a_r8_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |=> sys_rst_o);

    // R9: external reset only inside a system reset pulse
    a_r9_ext_in_sys: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_o |-> sys_rst_o);

endmodule

bind keysvc_wdog keysvc_wdog_chk #(.CNT_W(wdk_pkg::TMO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_rst_o (sys_rst_o),
    .ext_rst_o (ext_rst_o),
    .en_q      (st_q.ctrl.en),
    .lp_stop   (st_q.ctrl.lp_stop),
    .lowpwr_i  (lowpwr_i),
    .svc_ok    (svc_ok),
    .wr_en     (wr_en),
    .tmo_q     (st_q.ctrl.tmo),
    .cnt_q     (cnt_now)
);

// File: tb/keysvc_wdog_bench.sv
module keysvc_wdog_bench;

    localparam int PRE   = 4;
    localparam int PULSE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        lowpwr_i = 1'b0;
    logic        debug_i = 1'b0;
    logic        sys_rst_o, ext_rst_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_total = 0;

    always #5 clk = ~clk;

    keysvc_wdog #(.PRE_DIV(PRE), .PULSE_CYC(PULSE)) u_keysvc_wdog (
        .clk, .rst_n, .wr_en, .wr_sel, .wr_data,
        .lowpwr_i, .debug_i, .sys_rst_o, .ext_rst_o
    );

    // vector: {tmo[8], ext[1], nkeys[2], k0[16], k1[16], k2[16], last_reload[2]}
    localparam int NV = 8;
    localparam logic [60:0] VEC [NV] = '{
        {8'd2,   1'b1, 2'd2, 16'h5555, 16'hAAAA, 16'h0000, 2'd2},
        {8'd2,   1'b0, 2'd3, 16'h5555, 16'h1234, 16'hAAAA, 2'd0},
        {8'd2,   1'b1, 2'd3, 16'h5555, 16'h5555, 16'hAAAA, 2'd3},
        {8'd2,   1'b0, 2'd1, 16'hAAAA, 16'h0000, 16'h0000, 2'd0},
        {8'd2,   1'b0, 2'd3, 16'h5555, 16'hAAAA, 16'hAAAA, 2'd2},
        {8'd255, 1'b1, 2'd2, 16'h5555, 16'hAAAA, 16'h0000, 2'd2},
        {8'd3,   1'b0, 2'd2, 16'hAAAA, 16'h5555, 16'h0000, 2'd0},
        {8'd5,   1'b1, 2'd3, 16'hAAAA, 16'h5555, 16'hAAAA, 2'd3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        lowpwr_i = 1'b0;
        debug_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // write is captured at the posedge between the two negedges
    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] cw(input logic [7:0] t, input logic ext,
                                       input logic dbg, input logic lp);
        return {t, 3'b000, 1'b1, ext, 1'b1, dbg, lp};
    endfunction

    task automatic wait_rise(output int c);
        c = 0;
        while (!sys_rst_o && c < 5000) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic pulse_len(output int w);
        w = 0;
        while (sys_rst_o && w < 100) begin
            w++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        while (cyc_total < 150000) begin
            @(posedge clk);
            cyc_total++;
        end
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int c, w, t, e;
        logic x;
        // R1 reset state
        do_reset();
        chk(!sys_rst_o && !ext_rst_o, "R1 outputs low", int'(sys_rst_o), 0);

        // R11: service while disabled gives no pulse
        wr(1'b1, 16'h5555);
        wr(1'b1, 16'hAAAA);
        repeat (200) @(negedge clk);
        chk(!sys_rst_o, "R11 no pulse when disabled", int'(sys_rst_o), 0);

        // table of key sequences (R2, R5, R8, R9)
        for (int i = 0; i < NV; i++) begin
            logic [7:0] vt;
            logic vext;
            int nk, lr;
            vt   = VEC[i][60:53];
            vext = VEC[i][52];
            nk   = int'(VEC[i][51:50]);
            lr   = int'(VEC[i][1:0]);
            do_reset();
            wr(1'b0, cw(vt, vext, 1'b0, 1'b0));
            for (int k = 0; k < nk; k++) wr(1'b1, VEC[i][49 - 16*k -: 16]);
            t = (int'(vt) + 1) * PRE;
            e = t - 2 * (nk - lr);
            wait_rise(c);
            chk(c == e, $sformatf("R2/R5 vector %0d timeout", i), c, e);
            x = ext_rst_o;
            chk(x == vext, $sformatf("R9 vector %0d ext", i), int'(x), int'(vext));
            pulse_len(w);
            chk(w == PULSE, $sformatf("R8 vector %0d width", i), w, PULSE);
        end

        // R4: zero timeout field gives one prescale period
        do_reset();
        wr(1'b0, 16'h0014);
        wait_rise(c);
        chk(c == PRE, "R4 minimum timeout", c, PRE);

        // R8: rerun after expiry
        do_reset();
        wr(1'b0, cw(8'd1, 1'b0, 1'b0, 1'b0));
        wait_rise(c);
        chk(c == 8, "R8 first expiry", c, 8);
        c = 0;
        while (sys_rst_o && c < 100) begin @(negedge clk); c++; end
        while (!sys_rst_o && c < 1000) begin @(negedge clk); c++; end
        chk(c == 8, "R8 second expiry spacing", c, 8);

        // R3: clearing enable has no effect
        do_reset();
        wr(1'b0, cw(8'd1, 1'b0, 1'b0, 1'b0));
        wr(1'b0, 16'h0110);
        wait_rise(c);
        chk(c == 6, "R3 enable sticky", c, 6);

        // R5: control write between keys keeps checker armed
        do_reset();
        wr(1'b0, cw(8'd2, 1'b0, 1'b0, 1'b0));
        wr(1'b1, 16'h5555);
        wr(1'b0, cw(8'd2, 1'b0, 1'b0, 1'b0));
        wr(1'b1, 16'hAAAA);
        wait_rise(c);
        chk(c == 12, "R5 control write keeps arm", c, 12);

        // R6: low-power freeze
        do_reset();
        lowpwr_i = 1'b1;
        wr(1'b0, cw(8'd1, 1'b0, 1'b0, 1'b1));
        repeat (50) @(negedge clk);
        chk(!sys_rst_o, "R6 frozen no pulse", int'(sys_rst_o), 0);
        lowpwr_i = 1'b0;
        wait_rise(c);
        chk(c + 50 == 58, "R6 freeze delays expiry", c + 50, 58);

        // R7: debug freeze; R6 lowpwr ignored when its bit is clear
        do_reset();
        debug_i = 1'b1;
        lowpwr_i = 1'b1;
        wr(1'b0, cw(8'd1, 1'b0, 1'b1, 1'b0));
        repeat (50) @(negedge clk);
        debug_i = 1'b0;
        wait_rise(c);
        chk(c + 50 == 58, "R7 debug freeze (R6 bit clear)", c + 50, 58);
        lowpwr_i = 1'b0;

        // R10: software reset while disabled
        do_reset();
        wr(1'b0, 16'h0000);
        chk(sys_rst_o, "R10 soft pulse", int'(sys_rst_o), 1);
        chk(!ext_rst_o, "R10 ext low", int'(ext_rst_o), 0);
        pulse_len(w);
        chk(w == PULSE, "R10 soft width", w, PULSE);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule